// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers reset requests from six sources inside a small microcontroller and turns them into one timed recovery sequence, clocked by the crystal-derived reference clock. Two of the sources concern the supply: power-on and low-voltage detect. They first hold the core and peripheral clocks off for a long stabilisation count while the clock generator settles. Every source then goes through a shared phase in two halves. In the first half the block pulls the external reset pin low. In the second half only the internal reset is held.

When the internal reset drops, the block emits a one-cycle release strobe. It then counts the three cycles the core spends fetching its reset vector and raises a done flag. A six-bit status register records which source caused the last reset, and reading it clears it. A power-on event clears every other record.

The watchdog request is asynchronous to the clock. The block captures it with a set-on-edge latch and passes it through a synchroniser before it can act. A request that arrives while a sequence is running restarts that sequence, and a low-voltage request turns a short sequence into a long one.

Top module: `rst_seq`

## Requirements
- R1: While `pwr_on_i` is high, asynchronously and without a clock: `rst_int_o`=1, `clk_en_o`=0, `pin_drv_o`=0, `release_o`=0, `done_o`=0 and `stat_o`=6'b000001.
- R2: A supply reset (the cycle after `pwr_on_i` falls, or a clock edge with `low_volt_i` high) starts a stabilisation phase. For 4096 cycles it holds `rst_int_o`=1 and `clk_en_o`=0. `clk_en_o` is 1 in every other phase.
- R3: A clock edge with a watchdog, illegal-opcode, illegal-address or module request skips stabilisation. `done_o` rises 67 cycles after that edge, compared with 4163 cycles for a supply reset.
- R4: After stabilisation, or at once for the short sources, `pin_drv_o` is 1 for exactly 32 cycles. `rst_int_o` then stays 1 for a further 32 cycles with `pin_drv_o`=0.
- R5: In the cycle `rst_int_o` falls, `release_o` is high for that one cycle only. `done_o` goes high 3 cycles later and stays high until the next request.
- R6: A `wdog_i` pulse shorter than a clock period and away from any edge is accepted. It acts on the sequence at the third rising edge after the pulse.
- R7: Status bit map: bit0 power-on, bit1 low-voltage, bit2 watchdog, bit3 illegal opcode, bit4 illegal address, bit5 module request. At an edge that carries requests, the register becomes exactly the set of sources requesting at that edge. Two sources at the same edge set both bits.
- R8: An edge with `stat_rd_i` high and no request clears `stat_o` to zero after that edge. A request at the same edge wins over the read.
- R9: A request during a running sequence restarts it from the start phase of that source. A low-voltage request during a short sequence turns it into a long one.
- R10: A short-source request during the stabilisation phase leaves the sequence timing unchanged. It still updates the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| pwr_on_i | input | 1 | Power-on pulse, asynchronous, active high |
| low_volt_i | input | 1 | Low-voltage detect request |
| wdog_i | input | 1 | Watchdog timeout request, asynchronous |
| bad_op_i | input | 1 | Illegal opcode request |
| bad_addr_i | input | 1 | Illegal address request |
| mod_rst_i | input | 1 | Module-requested reset |
| stat_rd_i | input | 1 | Status register read strobe |
| rst_int_o | output | 1 | Internal reset, active high |
| clk_en_o | output | 1 | Core and peripheral clock enable |
| pin_drv_o | output | 1 | 1 = pull the external reset pin low |
| release_o | output | 1 | One-cycle core release strobe |
| done_o | output | 1 | Vector fetch cycles counted |
| stat_o | output | 6 | Reset source status |

## Verification
The bench applies a power-on event, single short-source pulses, and two short sources at the same edge. The contrast in total length separates the long path from the short path, and the simultaneous pair confirms that status bits combine. A sub-cycle watchdog pulse shows whether the asynchronous capture works and whether the synchroniser latency is correct. Restarts in the hold phase, an upgrade from low voltage, a short request during stabilisation, and reads with and without a colliding request separate the restart rules and show which of read and request wins.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int STAB_CYC  = 4096,
  parameter int PIN_CYC   = 32,
  parameter int HOLD_CYC  = 32,
  parameter int FETCH_CYC = 3
) (
  input  logic       clk_i,
  input  logic       pwr_on_i,
  input  logic       low_volt_i,
  input  logic       wdog_i,
  input  logic       bad_op_i,
  input  logic       bad_addr_i,
  input  logic       mod_rst_i,
  input  logic       stat_rd_i,
  output logic       rst_int_o,
  output logic       clk_en_o,
  output logic       pin_drv_o,
  output logic       release_o,
  output logic       done_o,
  output logic [5:0] stat_o
);
  localparam int M1   = (STAB_CYC > PIN_CYC) ? STAB_CYC : PIN_CYC;
  localparam int M2   = (HOLD_CYC > FETCH_CYC) ? HOLD_CYC : FETCH_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC) + 1;

  typedef enum logic [2:0] {PH_RUN, PH_STAB, PH_PIN, PH_HOLD, PH_FETCH} ph_t;

  ph_t           ph;
  logic [CW-1:0] cnt, lim;
  logic [5:0]    stat_q;
  logic          wd_lat, wd_s1, wd_s2, wd_s3;

  always_ff @(posedge clk_i or posedge pwr_on_i or posedge wdog_i)
    if (pwr_on_i)   wd_lat <= 1'b0;
    else if (wdog_i) wd_lat <= 1'b1;
    else if (wd_s2)  wd_lat <= 1'b0;

  always_ff @(posedge clk_i or posedge pwr_on_i)
    if (pwr_on_i) {wd_s3, wd_s2, wd_s1} <= 3'b000;
    else          {wd_s3, wd_s2, wd_s1} <= {wd_s2, wd_s1, wd_lat};

  wire       wd_fire   = wd_s2 & ~wd_s3;
  wire [5:0] req       = {mod_rst_i, bad_addr_i, bad_op_i, wd_fire, low_volt_i, 1'b0};
  wire       short_req = |req[5:2];

  always_comb
    case (ph)
      PH_STAB:  lim = CW'(STAB_CYC - 1);
      PH_PIN:   lim = CW'(PIN_CYC - 1);
      PH_HOLD:  lim = CW'(HOLD_CYC - 1);
      PH_FETCH: lim = CW'(FETCH_CYC - 1);
      default:  lim = '0;
    endcase

  always_ff @(posedge clk_i or posedge pwr_on_i)
    if (pwr_on_i) begin
      ph     <= PH_STAB;
      cnt    <= '0;
      stat_q <= 6'b000001;
    end else begin
      if (|req)          stat_q <= req;
      else if (stat_rd_i) stat_q <= '0;

      if (low_volt_i) begin
        ph  <= PH_STAB;
        cnt <= '0;
      end else if (short_req && ph != PH_STAB) begin
        ph  <= PH_PIN;
        cnt <= '0;
      end else if (ph != PH_RUN) begin
        if (cnt == lim) begin
          cnt <= '0;
          case (ph)
            PH_STAB: ph <= PH_PIN;
            PH_PIN:  ph <= PH_HOLD;
            PH_HOLD: ph <= PH_FETCH;
            default: ph <= PH_RUN;
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

  assign rst_int_o = (ph == PH_STAB) || (ph == PH_PIN) || (ph == PH_HOLD);
  assign clk_en_o  = (ph != PH_STAB);
  assign pin_drv_o = (ph == PH_PIN);
  assign release_o = (ph == PH_FETCH) && (cnt == '0);
  assign done_o    = (ph == PH_RUN);
  assign stat_o    = stat_q;
endmodule

module rst_seq_chk (
  input logic       clk_i,
  input logic       pwr_on_i,
  input logic       low_volt_i,
  input logic       bad_op_i,
  input logic       bad_addr_i,
  input logic       mod_rst_i,
  input logic       stat_rd_i,
  input logic       wd_fire,
  input logic       rst_int_o,
  input logic       clk_en_o,
  input logic       pin_drv_o,
  input logic       release_o,
  input logic       done_o,
  input logic [5:0] stat_o
);
  wire any_req = low_volt_i | bad_op_i | bad_addr_i | mod_rst_i | wd_fire;

  AST_GATED_IN_RESET: assert property (@(posedge clk_i) disable iff (pwr_on_i) !clk_en_o |-> rst_int_o); // R2
  AST_PIN_IN_RESET: assert property (@(posedge clk_i) disable iff (pwr_on_i) pin_drv_o |-> rst_int_o && clk_en_o); // R4
  AST_RELEASE_OUT_OF_RESET: assert property (@(posedge clk_i) disable iff (pwr_on_i) release_o |-> !rst_int_o && !done_o); // R5
  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (pwr_on_i) release_o |=> !release_o); // R5
  AST_DONE_AFTER_FETCH: assert property (@(posedge clk_i) disable iff (pwr_on_i) $rose(done_o) |-> $past(release_o, 3)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (pwr_on_i) stat_rd_i && !any_req |=> stat_o == 6'b0); // R8
  AST_REQ_SETS_STATUS: assert property (@(posedge clk_i) disable iff (pwr_on_i) bad_op_i |=> stat_o[3]); // R7
endmodule

bind rst_seq rst_seq_chk u_chk (.*);

// File: tb/tb_rst_seq.sv
`timescale 1ns/1ps
module tb_rst_seq;
  localparam int STAB = 4096, PIN = 32, HOLD = 32, FETCH = 3;

  logic clk = 1'b0;
  logic pwr_on = 1'b0, low_volt = 1'b0, wdog = 1'b0, bad_op = 1'b0;
  logic bad_addr = 1'b0, mod_rst = 1'b0, stat_rd = 1'b0;
  logic rst_int, clk_en, pin_drv, rel, done;
  logic [5:0] stat;

  int vectors = 0, miscompares = 0;
  int t = 0, wd_cnt = 0;
  bit long_seq = 1'b1;
  logic [5:0] m_stat = 6'b000001;
  string ctx = "R1";

  always #10 clk = ~clk;

  rst_seq dut (
    .clk_i(clk), .pwr_on_i(pwr_on), .low_volt_i(low_volt), .wdog_i(wdog),
    .bad_op_i(bad_op), .bad_addr_i(bad_addr), .mod_rst_i(mod_rst), .stat_rd_i(stat_rd),
    .rst_int_o(rst_int), .clk_en_o(clk_en), .pin_drv_o(pin_drv), .release_o(rel),
    .done_o(done), .stat_o(stat)
  );

  always @(posedge clk) begin
    if (!pwr_on) begin
      logic [5:0] r;
      bit fire, in_stab;
      fire    = (wd_cnt == 1);
      r       = {mod_rst, bad_addr, bad_op, fire, low_volt, 1'b0};
      in_stab = long_seq && (t < STAB);
      if (low_volt) begin
        long_seq = 1'b1; t = 0;
      end else if ((|r[5:2]) && !in_stab) begin
        long_seq = 1'b0; t = 0;
      end else if (t < 100000) begin
        t = t + 1;
      end
      if (|r) m_stat = r;
      else if (stat_rd) m_stat = 6'b0;
      if (wd_cnt > 0) wd_cnt = wd_cnt - 1;
    end
  end

  task automatic chk(input string tag, input string nm, input logic [5:0] act, input logic [5:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s %s: actual %h expected %h at %0t", ctx, tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e;
    e = long_seq ? t : t + STAB;
    chk("R2", "rst_int", {5'b0, rst_int}, {5'b0, e < STAB + PIN + HOLD});
    chk("R2", "clk_en",  {5'b0, clk_en},  {5'b0, e >= STAB});
    chk("R4", "pin_drv", {5'b0, pin_drv}, {5'b0, (e >= STAB) && (e < STAB + PIN)});
    chk("R5", "release", {5'b0, rel},     {5'b0, e == STAB + PIN + HOLD});
    chk("R3", "done",    {5'b0, done},    {5'b0, e >= STAB + PIN + HOLD + FETCH});
    chk("R7", "stat",    stat,            m_stat);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic pulse(input bit lv, input bit op, input bit ad, input bit md, input bit rd);
    low_volt = lv; bad_op = op; bad_addr = ad; mod_rst = md; stat_rd = rd;
    tick(1);
    low_volt = 0; bad_op = 0; bad_addr = 0; mod_rst = 0; stat_rd = 0;
  endtask

  task automatic wd_pulse();
    #2 wdog = 1'b1;
    #3 wdog = 1'b0;
    wd_cnt = 3;
  endtask

  initial begin
    #1 pwr_on = 1'b1;
    long_seq = 1'b1; t = 0; m_stat = 6'b000001;
    // R1: asynchronous power-on state, held over several edges
    ctx = "R1";
    tick(4);
    pwr_on = 1'b0;
    // R2: long recovery after power-on
    ctx = "R2";
    tick(STAB + PIN + HOLD + FETCH + 10);
    // R3: short source, illegal opcode
    ctx = "R3";
    pulse(0, 1, 0, 0, 0);
    tick(75);
    // R7: two sources at the same edge
    ctx = "R7";
    pulse(0, 0, 1, 1, 0);
    tick(75);
    // R6: sub-cycle watchdog pulse
    ctx = "R6";
    wd_pulse();
    tick(80);
    // R8: read clears, then a read colliding with a request
    ctx = "R8";
    pulse(0, 0, 0, 0, 1);
    tick(3);
    pulse(0, 0, 0, 1, 1);
    tick(75);
    pulse(0, 0, 0, 0, 1);
    tick(3);
    // R9: restart in hold phase, then upgrade to long
    ctx = "R9";
    pulse(0, 1, 0, 0, 0);
    tick(40);
    pulse(0, 0, 0, 1, 0);
    tick(20);
    pulse(1, 0, 0, 0, 0);
    tick(STAB + PIN + HOLD + FETCH + 10);
    // R10: short request during stabilisation keeps timing
    ctx = "R10";
    pulse(1, 0, 0, 0, 0);
    tick(100);
    pulse(0, 0, 1, 0, 0);
    tick(200);
    wd_pulse();
    tick(STAB + PIN + HOLD + FETCH);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule